// File: doc/BRIEF.md
# Headset Detection Debounce Controller

This block turns three noisy comparator levels into clean headset status. The first level says a plug is in the jack. The second says a microphone ring is loaded. The third is the headset button. The two plug levels share one programmable debounce window, and the button has its own. Each window is a fixed run of 8 matching samples. The samples are taken on a slow strobe, and the strobe period scales with the selected window. All timing comes from a single-cycle reference tick at 1 MHz, counted down to millisecond events.

The block reports a 2-bit status code and a debounced button level. A one-cycle pulse marks any change in either of them. The detection enable, the 3-bit plug window select and the 2-bit button window select arrive as plain inputs. The block brings the raw comparator levels into its clock domain through two-flop synchronisers.

Top module: `hsdet_debounce`

## Requirements
- R1: While `det_en` is 0, `hs_status` reads 00 and `btn_state` reads 0 from the second clock edge on, whatever the raw inputs do.
- R2: `hs_status` takes only the codes 00 (nothing plugged), 01 (plug without microphone) and 11 (plug with microphone); it never reads 10.
- R3: For `jack_sel` values 0 to 5, the plug strobe period is 2, 4, 8, 16, 32 or 64 ms. A new plug level is accepted on the 8th consecutive matching strobe. A pulse that covers fewer than 8 strobes is rejected, and a steady level is accepted no earlier than 6 periods and no later than 9 periods after it appears.
- R4: The `jack_sel` codes 6 and 7 behave exactly like code 5 (64 ms strobe, 512 ms window).
- R5: With `btn_sel` = 0 the button is not filtered: `btn_state` follows `btn_raw` with a latency of 4 clock edges.
- R6: With `btn_sel` = 1, 2 or 3 the button strobe period is 1, 2 or 4 ms, and acceptance needs 8 consecutive matching strobes, with the same bounds as R3.
- R7: One millisecond is `TICKS_PER_MS` pulses of `tick_1mhz`. No debounce state advances between ticks.
- R8: The microphone level is filtered only while the debounced plug level is high. Status 11 needs a full plug window of steady microphone after the plug is accepted, and a debounced removal of the plug gives 00 even when the microphone level stays high.
- R9: `chg_pulse` is high for exactly those cycles in which `hs_status` or `btn_state` differs from its value in the previous cycle.
- R10: Asserting enable after a disable, or changing a window select, restarts the prescalers and the sample runs of the affected filters. A run in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1mhz | input | 1 | Single-cycle 1 MHz reference enable |
| det_en | input | 1 | Detection enable |
| jack_sel | input | 3 | Plug debounce window select |
| btn_sel | input | 2 | Button debounce window select |
| jack_raw | input | 1 | Raw plug-present comparator level |
| mic_raw | input | 1 | Raw microphone-present comparator level |
| btn_raw | input | 1 | Raw button comparator level |
| hs_status | output | 2 | Debounced headset status code |
| btn_state | output | 1 | Debounced button level |
| chg_pulse | output | 1 | One-cycle marker of a status or button change |

## Verification
The hardest case to reach is a window select that changes while a sample run is part-way done. The discarded run would otherwise complete inside the new window, so the effect is seen only when the old run was close to finishing. The bench holds the plug level for six strobes of the short window. It then switches to a longer window and checks that nothing is accepted until eight new strobes of the longer period have passed. Glitch lengths and accept tests are drawn at random for every select code, including the reserved ones. A microphone level held high across a plug removal checks that removal wins.

// File: rtl/hsdet_pkg.sv
package hsdet_pkg;

  parameter int MAX_PERIOD_MS = 64;
  localparam int PERIOD_W = $clog2(MAX_PERIOD_MS + 1);

  typedef logic [PERIOD_W-1:0] period_t;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_PLAIN = 2'b01,
    HS_MIC   = 2'b11
  } hs_code_t;

  // plug strobe period in ms; reserved codes fold onto the longest setting
  function automatic period_t jack_period_ms(input logic [2:0] sel);
    logic [2:0] s;
    s = (sel > 3'd5) ? 3'd5 : sel;
    return period_t'(2) << s;
  endfunction

  // button strobe period in ms; code 0 is bypass, period unused
  function automatic period_t btn_period_ms(input logic [1:0] sel);
    if (sel == 2'd0) return period_t'(1);
    return period_t'(1) << (sel - 2'd1);
  endfunction

  function automatic hs_code_t enc_status(input logic en, input logic jack,
                                          input logic mic);
    if (!en || !jack) return HS_NONE;
    return mic ? HS_MIC : HS_PLAIN;
  endfunction

endpackage

// File: rtl/hsdet_strobe.sv
module hsdet_strobe #(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_i,
  input  logic                     clr_i,
  input  hsdet_pkg::period_t       period_i,
  output logic                     strobe_o
);
  localparam int TW = $clog2(TICKS_PER_MS + 1);
  localparam int PW = hsdet_pkg::PERIOD_W;

  logic [TW-1:0] tick_cnt;
  logic [PW-1:0] ms_cnt;
  logic          ms_evt;
  logic          last_ms;

  assign ms_evt  = tick_i && (tick_cnt == TW'(TICKS_PER_MS - 1));
  assign last_ms = (ms_cnt == (period_i - PW'(1)));
  assign strobe_o = ms_evt && last_ms;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      ms_cnt   <= '0;
    end else if (clr_i) begin
      tick_cnt <= '0;
      ms_cnt   <= '0;
    end else if (tick_i) begin
      tick_cnt <= ms_evt ? '0 : tick_cnt + TW'(1);
      if (ms_evt) ms_cnt <= last_ms ? '0 : ms_cnt + PW'(1);
    end
  end

  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (tick_cnt == '0 && ms_cnt == '0)); // R10

  AST_IDLE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> ($stable(tick_cnt) && $stable(ms_cnt))); // R7

endmodule

// File: rtl/hsdet_filter.sv
module hsdet_filter #(
  parameter int SAMPLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  input  logic strobe_i,
  input  logic bypass_i,
  input  logic clr_i,
  input  logic flush_i,
  output logic stable_o
);
  localparam int CW = $clog2(SAMPLES + 1);

  logic          cand;
  logic [CW-1:0] run_cnt;
  logic          run_done;

  assign run_done = (run_cnt == CW'(SAMPLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_o <= 1'b0;
      cand     <= 1'b0;
      run_cnt  <= CW'(SAMPLES);
    end else if (flush_i) begin
      stable_o <= 1'b0;
      cand     <= 1'b0;
      run_cnt  <= CW'(SAMPLES);
    end else if (clr_i) begin
      cand    <= stable_o;
      run_cnt <= CW'(SAMPLES);
    end else if (bypass_i) begin
      stable_o <= sample_i;
      cand     <= sample_i;
      run_cnt  <= CW'(SAMPLES);
    end else if (strobe_i) begin
      if (sample_i != cand) begin
        cand    <= sample_i;
        run_cnt <= CW'(1);
      end else if (run_cnt != CW'(SAMPLES)) begin
        run_cnt <= run_cnt + CW'(1);
        if (run_done) stable_o <= cand;
      end
    end
  end

  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !bypass_i && !flush_i) |=> $stable(stable_o)); // R3

  AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_i && !flush_i && !clr_i) |=> (stable_o == $past(sample_i))); // R5

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !stable_o); // R8

endmodule

// File: rtl/hsdet_debounce.sv
module hsdet_debounce #(
  parameter int TICKS_PER_MS = 1000,
  parameter int SAMPLES      = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1mhz,
  input  logic       det_en,
  input  logic [2:0] jack_sel,
  input  logic [1:0] btn_sel,
  input  logic       jack_raw,
  input  logic       mic_raw,
  input  logic       btn_raw,
  output logic [1:0] hs_status,
  output logic       btn_state,
  output logic       chg_pulse
);
  import hsdet_pkg::*;

  localparam int NIN = 3;

  // input synchronisers, one chain per comparator level
  logic [NIN-1:0] raw_vec;
  logic [NIN-1:0] sync_vec;
  assign raw_vec = {btn_raw, mic_raw, jack_raw};

  for (genvar g = 0; g < NIN; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], raw_vec[g]};
    end
    assign sync_vec[g] = chain[SYNC_STAGES-1];
  end

  // control history for restart detection
  logic       en_q;
  logic [2:0] jsel_q;
  logic [1:0] bsel_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      jsel_q <= '0;
      bsel_q <= '0;
    end else begin
      en_q   <= det_en;
      jsel_q <= jack_sel;
      bsel_q <= btn_sel;
    end
  end

  // named internal events
  logic     jack_clr, btn_clr, btn_bypass;
  logic     jack_strobe, btn_strobe;
  logic     jack_stable, mic_stable, btn_stable;
  period_t  jack_period, btn_period;
  hs_code_t status_next;
  logic     btn_next;

  assign jack_clr    = !det_en || (jack_sel != jsel_q);
  assign btn_clr     = !det_en || (btn_sel != bsel_q);
  assign btn_bypass  = (btn_sel == 2'd0);
  assign jack_period = jack_period_ms(jack_sel);
  assign btn_period  = btn_period_ms(btn_sel);

  hsdet_strobe #(.TICKS_PER_MS(TICKS_PER_MS)) u_jack_strobe (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_1mhz), .clr_i(jack_clr),
    .period_i(jack_period), .strobe_o(jack_strobe));

  hsdet_strobe #(.TICKS_PER_MS(TICKS_PER_MS)) u_btn_strobe (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_1mhz), .clr_i(btn_clr),
    .period_i(btn_period), .strobe_o(btn_strobe));

  hsdet_filter #(.SAMPLES(SAMPLES)) u_jack_filt (
    .clk(clk), .rst_n(rst_n), .sample_i(sync_vec[0]), .strobe_i(jack_strobe),
    .bypass_i(1'b0), .clr_i(jack_clr), .flush_i(!det_en),
    .stable_o(jack_stable));

  hsdet_filter #(.SAMPLES(SAMPLES)) u_mic_filt (
    .clk(clk), .rst_n(rst_n), .sample_i(sync_vec[1]), .strobe_i(jack_strobe),
    .bypass_i(1'b0), .clr_i(jack_clr), .flush_i(!det_en || !jack_stable),
    .stable_o(mic_stable));

  hsdet_filter #(.SAMPLES(SAMPLES)) u_btn_filt (
    .clk(clk), .rst_n(rst_n), .sample_i(sync_vec[2]), .strobe_i(btn_strobe),
    .bypass_i(btn_bypass), .clr_i(btn_clr), .flush_i(!det_en),
    .stable_o(btn_stable));

  assign status_next = enc_status(det_en, jack_stable, mic_stable);
  assign btn_next    = det_en && btn_stable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_status <= HS_NONE;
      btn_state <= 1'b0;
      chg_pulse <= 1'b0;
    end else begin
      hs_status <= status_next;
      btn_state <= btn_next;
      chg_pulse <= (status_next != hs_status) || (btn_next != btn_state);
    end
  end

  AST_NO_CODE_10: assert property (@(posedge clk) disable iff (!rst_n)
    hs_status != 2'b10); // R2

  AST_OFF_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !en_q) |-> (hs_status == 2'b00 && !btn_state)); // R1

  AST_PULSE_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pulse |-> (hs_status != $past(hs_status) || btn_state != $past(btn_state))); // R9

  AST_CHANGE_RAISES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_status != $past(hs_status) || btn_state != $past(btn_state)) |-> chg_pulse); // R9

  AST_MIC_AFTER_PLUG: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_status == 2'b11) |-> $past(jack_stable)); // R8

endmodule

// File: tb/hsdet_debounce_bench.sv
module hsdet_debounce_bench;
  localparam int TPM = 4;
  localparam int TDIV = 2;
  localparam int MSC = TPM * TDIV;
  localparam int WD_CYCLES = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic det_en = 1'b0;
  logic [2:0] jack_sel = '0;
  logic [1:0] btn_sel = '0;
  logic jack_raw = 1'b0, mic_raw = 1'b0, btn_raw = 1'b0;
  logic [1:0] hs_status;
  logic btn_state, chg_pulse;

  int nchk = 0, nfail = 0;
  int pcount = 0, pmis = 0;
  logic [1:0] prev_st = '0;
  logic prev_b = 1'b0;

  always #10 clk = ~clk;

  hsdet_debounce #(.TICKS_PER_MS(TPM)) u_hsdet_debounce (
    .clk(clk), .rst_n(rst_n), .tick_1mhz(tick), .det_en(det_en),
    .jack_sel(jack_sel), .btn_sel(btn_sel), .jack_raw(jack_raw),
    .mic_raw(mic_raw), .btn_raw(btn_raw), .hs_status(hs_status),
    .btn_state(btn_state), .chg_pulse(chg_pulse));

  int tdiv_cnt = 0;
  always @(negedge clk) begin
    tick <= (tdiv_cnt == 0);
    tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
  end

  // R9 monitor: pulse must coincide with every output change
  always @(negedge clk) begin
    if (rst_n) begin
      if (((hs_status != prev_st) || (btn_state != prev_b)) != chg_pulse) pmis++;
      if (chg_pulse) pcount++;
    end
    prev_st = hs_status;
    prev_b  = btn_state;
  end

  function automatic int jper(int sel);
    return (sel >= 5) ? 64 : (1 << (sel + 1));
  endfunction

  function automatic int bper(int sel);
    return 1 << (sel - 1);
  endfunction

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wait_ms(int n);
    repeat (n * MSC) @(negedge clk);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R3 got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 reset status", hs_status, 0);
    chk("R1 reset button", btn_state, 0);
    chk("R9 reset pulse", chg_pulse, 0);

    // R1: disabled with everything high
    jack_raw = 1; mic_raw = 1; btn_raw = 1;
    wait_ms(40);
    chk("R1 disabled status", hs_status, 0);
    chk("R1 disabled button", btn_state, 0);
    jack_raw = 0; mic_raw = 0; btn_raw = 0;
    det_en = 1;
    wait_cyc(4);

    // R3 / R4: every plug select, random glitch then steady level
    for (int s = 0; s < 8; s++) begin
      int p, w, gl, pc0;
      jack_sel = 3'(s);
      p = jper(s); w = 8 * p;
      wait_cyc(4);
      gl = 1 + int'($urandom % (6 * p));
      jack_raw = 1; wait_ms(gl); jack_raw = 0;
      wait_ms(w + p);
      chk((s > 5) ? "R4 glitch rejected" : "R3 glitch rejected", hs_status, 0);
      pc0 = pcount;
      jack_raw = 1;
      wait_ms(6 * p);
      chk((s > 5) ? "R4 not early" : "R3 not early", hs_status, 0);
      wait_ms(3 * p); wait_cyc(4);
      chk((s > 5) ? "R4 accepted" : "R3 accepted", hs_status, 1);
      chk("R9 one pulse per accept", pcount - pc0, 1);
      jack_raw = 0;
      wait_ms(w + p); wait_cyc(4);
      chk("R3 release", hs_status, 0);
    end

    // R8: microphone follows plug acceptance
    jack_sel = 3'd0;
    wait_cyc(4);
    jack_raw = 1; mic_raw = 1;
    wait_ms(18); wait_cyc(4);
    chk("R8 plug first", hs_status, 1);
    wait_ms(18); wait_cyc(4);
    chk("R2 mic code", hs_status, 3);

    // R1 / R10: disable then re-enable restarts
    det_en = 0;
    wait_cyc(2);
    chk("R1 disable fast", hs_status, 0);
    wait_ms(30);
    chk("R1 disable held", hs_status, 0);
    det_en = 1;
    wait_ms(12);
    chk("R10 reenable restart", hs_status, 0);
    wait_ms(24); wait_cyc(4);
    chk("R8 mic again", hs_status, 3);
    jack_raw = 0;
    wait_ms(12);
    chk("R3 removal not early", hs_status, 3);
    wait_ms(6); wait_cyc(4);
    chk("R8 removal wins", hs_status, 0);
    wait_ms(40);
    chk("R8 mic alone ignored", hs_status, 0);
    mic_raw = 0;

    // R10: select change discards a nearly complete run
    jack_raw = 1;
    wait_ms(12);
    jack_sel = 3'd1;
    wait_ms(24);
    chk("R10 select restart", hs_status, 0);
    wait_ms(16); wait_cyc(4);
    chk("R10 accepted after restart", hs_status, 1);
    jack_raw = 0;
    wait_ms(40); wait_cyc(4);

    // R5: unfiltered button
    btn_sel = 2'd0;
    wait_cyc(2);
    btn_raw = 1;
    wait_cyc(2);
    chk("R5 bypass latency", btn_state, 0);
    wait_cyc(2);
    chk("R5 bypass follows", btn_state, 1);
    btn_raw = 0;
    wait_cyc(4);
    chk("R5 bypass release", btn_state, 0);

    // R6: filtered button settings
    for (int s = 1; s < 4; s++) begin
      int p, w, gl;
      btn_sel = 2'(s);
      p = bper(s); w = 8 * p;
      wait_cyc(4);
      gl = 1 + int'($urandom % (6 * p));
      btn_raw = 1; wait_ms(gl); btn_raw = 0;
      wait_ms(w + p);
      chk("R6 glitch rejected", btn_state, 0);
      btn_raw = 1;
      wait_ms(6 * p);
      chk("R6 not early", btn_state, 0);
      wait_ms(3 * p); wait_cyc(4);
      chk("R6 accepted", btn_state, 1);
      btn_raw = 0;
      wait_ms(w + p); wait_cyc(4);
      chk("R6 release", btn_state, 0);
    end

    // R7: with the tick held off nothing is accepted
    btn_sel = 2'd1;
    wait_cyc(4);
    force tick = 1'b0;
    btn_raw = 1;
    wait_ms(40);
    chk("R7 no tick no progress", btn_state, 0);
    release tick;
    wait_ms(12);
    chk("R7 tick resumes", btn_state, 1);
    btn_raw = 0;
    wait_ms(12);

    chk("R9 pulse coincidence mismatches", pmis, 0);
    summary();
    $finish;
  end

endmodule